// File: doc/BRIEF.md
# Interrupt-Driven Contactless Reader Sequencer

This block is the master-side controller for a contactless-card reader chip. The chip sits behind a byte-wide SPI engine with a slave-select line. The sequencer builds every command byte and decides how bytes are grouped into select windows. It also decides which register each returned byte belongs to. The bit-level shifting stays in the engine, which runs a start/busy/done handshake for each byte. Slave select is driven by separate open and close pulses, so one window can carry several bytes.

After reset the sequencer waits a power-up delay, set by the clock frequency and a time in microseconds. It then writes the chip status register to turn on the RF output at half power, and sends the inventory frame. After that it waits for the interrupt line. Each interrupt starts a fixed service run:

- Read and latch the interrupt status.
- If the status is clean, read the FIFO count and drain that many bytes onto a valid/data stream.
- Reset the FIFO.
- Read the signal-strength register.
- Return to idle.

Top module: `rdr_seq`

## Requirements
- R1: No slave-select open and no byte start occur until DELAY_CYC = CLK_HZ/1e6*PWRUP_US cycles have passed after reset. While reset is held, every output is 0.
- R2: Each command byte is {direct, read, burst, addr[4:0]}, with the direct flag in bit 7, read in bit 6, burst in bit 5 and the register address in bits 4:0.
- R3: The first select window carries exactly the two bytes 0x00 then 0x30.
- R4: The second window carries exactly 0x8F, 0x91, 0x3D, 0x00, 0x30, 0x26, 0x01, 0x00. The block then idles until the interrupt line is seen high.
- R5: A service starts with one window of 0x6C followed by 0x00. The byte received during the 0x00 is latched on `irq_status`.
- R6: If any of status bits 4:1 are set, `err_flag` goes to 1 and no 0x5C or 0x7F window follows. The block goes straight on to the FIFO-reset window. `err_flag` returns to 0 at the next service whose status bits 4:1 are all clear.
- R7: A status of exactly 0x80 (transmit complete) also skips the FIFO count read and the drain, and leaves `err_flag` at 0.
- R8: On a clean status other than 0x80, one window of 0x5C, 0x00 reads the FIFO count. Then one window of 0x7F followed by N bytes of 0x00 drains the FIFO, where N is the low nibble of the returned count plus one. Bits 7:4 of the count are ignored.
- R9: Each byte received during the drain appears on `rx_data` with a one-cycle `rx_valid` pulse, in order. `rx_last` is high together with `rx_valid` only on the N-th byte.
- R10: Every service ends with a window holding only 0x8F, then a window of 0x4F, 0x00. The byte received during that 0x00 is latched on `rssi`, and the block returns to idle.
- R11: The interrupt line is ignored outside idle. A high level that starts and ends during a service begins no further service.
- R12: `xfer_start` is a one-cycle pulse that follows a cycle with `xfer_busy` low, and it occurs only inside an open select window. Select open and close pulses alternate, starting with an open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 1 | Reader interrupt line (asynchronous) |
| xfer_busy | input | 1 | SPI engine is shifting a byte |
| xfer_done | input | 1 | One-cycle pulse: byte finished, `xfer_rx` valid |
| xfer_rx | input | 8 | Byte shifted in from the chip |
| xfer_start | output | 1 | One-cycle request to shift `xfer_tx` |
| xfer_tx | output | 8 | Byte to shift out |
| sel_assert | output | 1 | Pulse: open a select window |
| sel_release | output | 1 | Pulse: close the select window |
| rx_valid | output | 1 | Drained FIFO byte present |
| rx_data | output | 8 | Drained FIFO byte |
| rx_last | output | 1 | Final byte of this drain |
| irq_status | output | 8 | Latched interrupt status |
| rssi | output | 8 | Latched signal-strength byte |
| err_flag | output | 1 | Last status showed an error |

## Verification
The hardest case to reach is an interrupt level that rises while a service is still running. Outside idle the sequencer must ignore it, yet nothing at the ports shows when the block is idle. The bench's SPI engine model raises the interrupt for a few cycles right after it sees the 0x7F drain command. It drops the line again well before the final window. The bench then checks that no new select window opens after the service ends. It also checks the drain at the extreme nibble values, where the upper count bits must be ignored.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic [2:0] {PH_PWR, PH_IDLE, PH_OPEN, PH_SEND, PH_WAIT, PH_CLOSE} phase_t;
  typedef enum logic [2:0] {W_CFG, W_INV, W_STAT, W_FSTAT, W_DRAIN, W_RST, W_RSSI} win_t;

  localparam logic [4:0] A_IRQ_ST = 5'h0C;
  localparam logic [4:0] A_FCOUNT = 5'h1C;
  localparam logic [4:0] A_FIFO   = 5'h1F;
  localparam logic [4:0] A_SIGSTR = 5'h0F;
  localparam logic [4:0] D_FRESET = 5'h0F;

  function automatic logic [7:0] cmd_byte(input logic direct, input logic rd,
                                          input logic burst, input logic [4:0] addr);
    return {direct, rd, burst, addr};
  endfunction
endpackage

// File: rtl/rdr_delay.sv
module rdr_delay #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int W = $clog2(CYCLES + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      if (cnt != W'(CYCLES)) cnt <= cnt + 1'b1;
      done <= (cnt == W'(CYCLES));
    end
  end
endmodule

// File: rtl/rdr_sync.sv
module rdr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) sr <= rst ? 1'b0 : d;
    end else begin : g_many
      always_ff @(posedge clk) sr <= rst ? '0 : {sr[STAGES-2:0], d};
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/rdr_init_rom.sv
module rdr_init_rom (
  input  logic [3:0] sel,
  output logic [7:0] val
);
  always_comb begin
    case (sel)
      4'd0:    val = 8'h00;
      4'd1:    val = 8'h30;
      4'd2:    val = 8'h8F;
      4'd3:    val = 8'h91;
      4'd4:    val = 8'h3D;
      4'd5:    val = 8'h00;
      4'd6:    val = 8'h30;
      4'd7:    val = 8'h26;
      4'd8:    val = 8'h01;
      default: val = 8'h00;
    endcase
  end
endmodule

// File: rtl/rdr_seq.sv
module rdr_seq
  import rdr_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int PWRUP_US = 30_000,
  parameter int SYNC_FF  = 2,
  parameter int CNT_W    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_in,
  input  logic       xfer_busy,
  input  logic       xfer_done,
  input  logic [7:0] xfer_rx,
  output logic       xfer_start,
  output logic [7:0] xfer_tx,
  output logic       sel_assert,
  output logic       sel_release,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_last,
  output logic [7:0] irq_status,
  output logic [7:0] rssi,
  output logic       err_flag
);
  localparam int DELAY_CYC = (CLK_HZ / 1_000_000) * PWRUP_US;
  localparam int IDX_W     = CNT_W + 1;

  phase_t           ph;
  win_t             win;
  logic [IDX_W-1:0] idx, len;
  logic [CNT_W-1:0] fcount;
  logic [7:0]       tx_byte, rom_val;
  logic [3:0]       rom_sel;
  logic             dly_done, irq_s, is_last, st_err, st_txonly;

  rdr_delay #(.CYCLES(DELAY_CYC)) u_dly (.clk(clk), .rst(rst), .done(dly_done));
  rdr_sync  #(.STAGES(SYNC_FF))   u_sync (.clk(clk), .rst(rst), .d(irq_in), .q(irq_s));
  rdr_init_rom u_rom (.sel(rom_sel), .val(rom_val));

  assign rom_sel   = (win == W_INV) ? idx[3:0] + 4'd2 : idx[3:0];
  assign is_last   = (idx == len - 1'b1);
  assign st_err    = |irq_status[4:1];
  assign st_txonly = (irq_status == 8'h80);

  always_comb begin
    len     = IDX_W'(2);
    tx_byte = 8'h00;
    case (win)
      W_CFG:   tx_byte = rom_val;
      W_INV:   begin len = IDX_W'(8); tx_byte = rom_val; end
      W_STAT:  if (idx == '0) tx_byte = cmd_byte(1'b0, 1'b1, 1'b1, A_IRQ_ST);
      W_FSTAT: if (idx == '0) tx_byte = cmd_byte(1'b0, 1'b1, 1'b0, A_FCOUNT);
      W_DRAIN: begin
        len = IDX_W'(fcount) + IDX_W'(2);
        if (idx == '0) tx_byte = cmd_byte(1'b0, 1'b1, 1'b1, A_FIFO);
      end
      W_RST:   begin len = IDX_W'(1); tx_byte = cmd_byte(1'b1, 1'b0, 1'b0, D_FRESET); end
      W_RSSI:  if (idx == '0) tx_byte = cmd_byte(1'b0, 1'b1, 1'b0, A_SIGSTR);
      default: tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_PWR;  win <= W_CFG;  idx <= '0;  fcount <= '0;
      xfer_start <= 1'b0;  xfer_tx <= 8'h00;
      sel_assert <= 1'b0;  sel_release <= 1'b0;
      rx_valid <= 1'b0;  rx_data <= 8'h00;  rx_last <= 1'b0;
      irq_status <= 8'h00;  rssi <= 8'h00;  err_flag <= 1'b0;
    end else begin
      xfer_start  <= 1'b0;
      sel_assert  <= 1'b0;
      sel_release <= 1'b0;
      rx_valid    <= 1'b0;
      rx_last     <= 1'b0;
      case (ph)
        PH_PWR:  if (dly_done) begin win <= W_CFG; ph <= PH_OPEN; end
        PH_IDLE: if (irq_s) begin win <= W_STAT; ph <= PH_OPEN; end
        PH_OPEN: begin sel_assert <= 1'b1; idx <= '0; ph <= PH_SEND; end
        PH_SEND: if (!xfer_busy) begin
          xfer_start <= 1'b1;
          xfer_tx    <= tx_byte;
          ph         <= PH_WAIT;
        end
        PH_WAIT: if (xfer_done) begin
          if (idx != '0) begin
            case (win)
              W_STAT:  irq_status <= xfer_rx;
              W_FSTAT: fcount <= xfer_rx[CNT_W-1:0];
              W_DRAIN: begin rx_valid <= 1'b1; rx_data <= xfer_rx; rx_last <= is_last; end
              W_RSSI:  rssi <= xfer_rx;
              default: ;
            endcase
          end
          idx <= idx + 1'b1;
          ph  <= is_last ? PH_CLOSE : PH_SEND;
        end
        PH_CLOSE: begin
          sel_release <= 1'b1;
          ph          <= PH_OPEN;
          case (win)
            W_CFG:   win <= W_INV;
            W_INV:   ph  <= PH_IDLE;
            W_STAT: begin
              err_flag <= st_err;
              win      <= (st_err || st_txonly) ? W_RST : W_FSTAT;
            end
            W_FSTAT: win <= W_DRAIN;
            W_DRAIN: win <= W_RST;
            W_RST:   win <= W_RSSI;
            default: ph  <= PH_IDLE;
          endcase
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdr_seq_chk.sv
module rdr_seq_chk #(
  parameter int DELAY_CYC = 100
) (
  input logic       clk,
  input logic       rst,
  input logic       xfer_start,
  input logic [7:0] xfer_tx,
  input logic       xfer_busy,
  input logic       sel_assert,
  input logic       sel_release,
  input logic       rx_valid,
  input logic       rx_last,
  input logic       err_flag
);
  localparam int W = $clog2(DELAY_CYC + 1);
  logic [W-1:0] since;
  logic         win_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      since    <= '0;
      win_open <= 1'b0;
    end else begin
      if (since != W'(DELAY_CYC)) since <= since + 1'b1;
      if (sel_assert) win_open <= 1'b1;
      else if (sel_release) win_open <= 1'b0;
    end
  end

  // R1
  p_no_early_open_r1: assert property (@(posedge clk) disable iff (rst)
    sel_assert |-> since == W'(DELAY_CYC));
  // R12
  p_start_after_idle_r12: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> !$past(xfer_busy));
  p_start_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);
  p_start_in_window_r12: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> win_open);
  p_open_when_closed_r12: assert property (@(posedge clk) disable iff (rst)
    sel_assert |-> !win_open);
  p_close_when_open_r12: assert property (@(posedge clk) disable iff (rst)
    sel_release |-> win_open);
  // R9
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  p_last_with_valid_r9: assert property (@(posedge clk) disable iff (rst)
    rx_last |-> rx_valid);
  // R6
  p_no_drain_on_err_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && err_flag) |-> (xfer_tx != 8'h7F && xfer_tx != 8'h5C));
endmodule

bind rdr_seq rdr_seq_chk #(.DELAY_CYC(DELAY_CYC)) u_chk (
  .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_tx(xfer_tx),
  .xfer_busy(xfer_busy), .sel_assert(sel_assert), .sel_release(sel_release),
  .rx_valid(rx_valid), .rx_last(rx_last), .err_flag(err_flag)
);

// File: tb/rdr_seq_bench.sv
module rdr_seq_bench;
  localparam int DLY = 100;  // 50 MHz * 2 us

  logic clk = 1'b0, rst = 1'b1, irq_in = 1'b0;
  logic xfer_busy = 1'b0, xfer_done = 1'b0;
  logic [7:0] xfer_rx = 8'h00;
  logic xfer_start, sel_assert, sel_release, rx_valid, rx_last, err_flag;
  logic [7:0] xfer_tx, rx_data, irq_status, rssi;

  always #10 clk = ~clk;

  rdr_seq #(.CLK_HZ(50_000_000), .PWRUP_US(2)) u_rdr_seq (
    .clk(clk), .rst(rst), .irq_in(irq_in), .xfer_busy(xfer_busy),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx), .xfer_start(xfer_start),
    .xfer_tx(xfer_tx), .sel_assert(sel_assert), .sel_release(sel_release),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .irq_status(irq_status), .rssi(rssi), .err_flag(err_flag));

  int checks = 0, errors = 0, cyc = 0, first_sel = -1;
  int nb = 0, nwin = 0, nrx = 0, dk = 0, cnt = 0, glitch = 0;
  bit newwin = 0, svc_end = 0, glitch_en = 0;
  logic [7:0] lg_b[64];
  int         lg_w[64];
  logic [7:0] rx_d[32];
  logic       rx_l[32];
  logic [7:0] firstb = 8'h00, lastb = 8'h00, resp;
  logic [7:0] st_val = 0, fs_val = 0, ss_val = 0, dbase = 0;
  logic [7:0] ex_b[64];
  int         ex_w[64];
  int         nex = 0, exw = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // SPI engine model, logger and interrupt model, all on the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    if (xfer_done) xfer_done = 1'b0;
    if (xfer_busy) begin
      cnt--;
      if (cnt == 0) begin xfer_busy = 1'b0; xfer_done = 1'b1; xfer_rx = resp; end
    end
    if (glitch > 0) begin glitch--; if (glitch == 0) irq_in = 1'b0; end
    if (sel_assert) begin
      nwin++; newwin = 1; dk = 0;
      if (first_sel < 0) first_sel = cyc;
    end
    if (sel_release && firstb == 8'h4F) svc_end = 1;
    if (xfer_start) begin
      if (newwin) begin firstb = xfer_tx; newwin = 0; resp = 8'h00; end
      else if (lastb == 8'h6C) resp = st_val;
      else if (lastb == 8'h5C) resp = fs_val;
      else if (lastb == 8'h4F) resp = ss_val;
      else if (firstb == 8'h7F) begin resp = dbase + 8'(dk); dk++; end
      else resp = 8'h00;
      if (nb < 64) begin lg_b[nb] = xfer_tx; lg_w[nb] = nwin; end
      nb++;
      if (xfer_tx == 8'h6C) irq_in = 1'b0;
      if (xfer_tx == 8'h7F && glitch_en) begin irq_in = 1'b1; glitch = 5; end
      lastb = xfer_tx;
      xfer_busy = 1'b1; cnt = 3;
    end
    if (rx_valid && nrx < 32) begin rx_d[nrx] = rx_data; rx_l[nrx] = rx_last; nrx++; end
  end

  task automatic clear_log();
    nb = 0; nwin = 0; nrx = 0; nex = 0; exw = 0; svc_end = 0;
  endtask

  task automatic ex_win(input logic [7:0] b0, input int zeros);
    exw++;
    ex_b[nex] = b0; ex_w[nex] = exw; nex++;
    for (int i = 0; i < zeros; i++) begin ex_b[nex] = 8'h00; ex_w[nex] = exw; nex++; end
  endtask

  task automatic cmp_log(input string req);
    int bad = -1;
    chk(nb == nex, req, "byte count", nb, nex);
    chk(nwin == exw, req, "window count", nwin, exw);
    for (int i = 0; i < nex && i < nb; i++)
      if (bad < 0 && (lg_b[i] != ex_b[i] || lg_w[i] != ex_w[i])) bad = i;
    if (bad >= 0) chk(0, req, $sformatf("byte %0d (window %0d)", bad, lg_w[bad]),
                      lg_b[bad], ex_b[bad]);
    else chk(1, req, "bytes", 0, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(xfer_start == 0 && sel_assert == 0 && sel_release == 0, "R1", "ctl in reset", 0, 0);
    chk(rx_valid == 0 && rx_last == 0 && err_flag == 0, "R1", "flags in reset", 0, 0);
    chk(irq_status == 0, "R1", "irq_status in reset", irq_status, 0);
    chk(rssi == 0, "R1", "rssi in reset", rssi, 0);
    clear_log();
    first_sel = -1;
    @(posedge clk); rst = 1'b0; cyc = 0;
  endtask

  task automatic t_powerup();
    repeat (DLY + 300) @(negedge clk);
    chk(first_sel >= DLY, "R1", "first select cycle", first_sel, DLY);
    ex_win(8'h00, 0); ex_b[nex] = 8'h30; ex_w[nex] = exw; nex++;
    exw++;
    foreach (ex_b[i]) if (i < 8) begin
      ex_w[nex] = exw;
      ex_b[nex] = (i == 0) ? 8'h8F : (i == 1) ? 8'h91 : (i == 2) ? 8'h3D : (i == 3) ? 8'h00 :
                  (i == 4) ? 8'h30 : (i == 5) ? 8'h26 : (i == 6) ? 8'h01 : 8'h00;
      nex++;
    end
    cmp_log("R3 R4 R2");
    chk(nrx == 0, "R4", "no stream at init", nrx, 0);
  endtask

  task automatic t_service(input string req, input logic [7:0] st, input logic [7:0] fs,
                           input logic [7:0] ss, input logic [7:0] base, input bit glt);
    int n, w0;
    bit skip;
    clear_log();
    st_val = st; fs_val = fs; ss_val = ss; dbase = base; glitch_en = glt;
    skip = (|st[4:1]) || (st == 8'h80);
    n = skip ? 0 : int'(fs[3:0]) + 1;
    irq_in = 1'b1;
    for (int i = 0; i < 3000 && !svc_end; i++) @(negedge clk);
    chk(svc_end, req, "service finished", svc_end, 1);
    repeat (4) @(negedge clk);
    ex_win(8'h6C, 1);
    if (!skip) begin ex_win(8'h5C, 1); ex_win(8'h7F, n); end
    ex_win(8'h8F, 0);
    ex_win(8'h4F, 1);
    cmp_log({req, " R5 R10"});
    chk(irq_status == st, "R5", "irq_status", irq_status, st);
    chk(rssi == ss, "R10", "rssi", rssi, ss);
    chk(err_flag == |st[4:1], "R6", "err_flag", err_flag, |st[4:1]);
    chk(nrx == n, "R9", "stream length", nrx, n);
    for (int i = 0; i < n && i < nrx; i++) begin
      chk(rx_d[i] == base + 8'(i), "R9", $sformatf("data %0d", i), rx_d[i], base + 8'(i));
      chk(rx_l[i] == (i == n - 1), "R9", $sformatf("last %0d", i), rx_l[i], (i == n - 1));
    end
    w0 = nwin;
    repeat (150) @(negedge clk);
    chk(nwin == w0, "R11", "no extra service", nwin, w0);
    glitch_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_powerup();
    t_service("R8", 8'h40, 8'h03, 8'h5A, 8'h10, 1'b0);
    t_service("R6", 8'h04, 8'h03, 8'h33, 8'h20, 1'b0);
    t_service("R8 R6", 8'h40, 8'h00, 8'h44, 8'hA0, 1'b0);
    t_service("R7", 8'h80, 8'h05, 8'h66, 8'h30, 1'b0);
    t_service("R8 R11", 8'h40, 8'hFF, 8'h77, 8'hC0, 1'b1);
    t_service("R6", 8'h12, 8'h02, 8'h11, 8'h00, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule